// File: doc/BRIEF.md
# I2C Master Status Flags and Interrupt Logic

This block keeps the status side of an I2C master controller. The byte engine sends it single-cycle event pulses: start sent, 10-bit header sent, byte finished, address phase ended, acknowledge failure, stop seen, arbitration lost and bus error. Each pulse sets a sticky flag. The block also registers four live levels from the engine: bus busy, transmitter mode, master mode and addressed. Software reads the flags through two 8-bit status registers. Each sticky flag is cleared as a side effect of one particular register access: a data write, a data read, a control write, or a read of the second status register.

The block also holds the 8-bit control register. Two of its bits are used here: the peripheral enable and the interrupt enable. A summary event bit is the OR of every pending sticky flag. The interrupt output is that summary gated by the interrupt enable. Register access uses a 32-bit bus that carries 8-bit registers. A write takes effect only when the byte is repeated in lanes 7:0 and 23:16. A read returns the byte copied into all four lanes.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset, the control register, all sticky flags, all live status bits, the read data and `irq_o` are 0.
- R2: A write takes effect only when `reg_wdata_i[7:0]` equals `reg_wdata_i[23:16]`. Any other write leaves every register and flag unchanged.
- R3: Word offsets on `reg_addr_i` are: control 0, status-1 at 1, status-2 at 2, data at 6. A read drives the selected byte into all four byte lanes of `reg_rdata_o` from the clock edge that ends the access. The data offset returns `data_byte_i`.
- R4: Status-1 bit layout:
  - bit7: summary event
  - bit6: 10-bit header sent
  - bit5: transmitter
  - bit4: bus busy
  - bit3: byte finished
  - bit2: addressed
  - bit1: master
  - bit0: start sent

  Bits 5, 4, 2 and 1 follow `transmit_i`, `bus_busy_i`, `addressed_i` and `master_i` one cycle later, and no read clears them.
- R5: Status-2 bit layout:
  - bit5: address end
  - bit4: acknowledge failure
  - bit3: stop seen
  - bit2: arbitration lost
  - bit1: bus error

  Bits 7, 6 and 0 read 0. Each event pulse sets its sticky flag at the next edge.
- R6: A valid data write clears the start-sent and 10-bit-header flags. It also clears the byte-finished flag when in transmitter mode.
- R7: A data read clears the byte-finished flag only when in receiver mode (transmitter bit 0).
- R8: A valid control write with bit5 (peripheral enable) set clears the address-end flag.
- R9: A read of status-2 clears the acknowledge-failure, stop, arbitration-lost and bus-error flags. A read of status-1 clears nothing.
- R10: The summary bit is 1 exactly when a sticky flag is pending. `irq_o` is 1 exactly when the summary bit and control bit0 (interrupt enable) are both 1, and it changes at the same edge as the flags.
- R11: An event pulse in the same cycle as an access that would clear its flag leaves the flag set.
- R12: While control bit5 is 0, all sticky flags are 0 and event pulses are ignored. A control write that clears bit5 clears every flag at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_i | input | 1 | Pulse: start condition sent |
| ev_hdr10_i | input | 1 | Pulse: 10-bit address header sent |
| ev_byte_i | input | 1 | Pulse: byte transfer finished |
| ev_addr_end_i | input | 1 | Pulse: address phase ended |
| ev_ack_fail_i | input | 1 | Pulse: acknowledge failure |
| ev_stop_i | input | 1 | Pulse: stop condition seen |
| ev_arb_lost_i | input | 1 | Pulse: arbitration lost |
| ev_bus_err_i | input | 1 | Pulse: bus error |
| bus_busy_i | input | 1 | Level: bus busy between start and stop |
| transmit_i | input | 1 | Level: engine in transmitter mode |
| master_i | input | 1 | Level: engine in master mode |
| addressed_i | input | 1 | Level: address matched or sent |
| data_byte_i | input | DATA_W | Current data register byte from the engine |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | ADDR_W | Register word offset |
| reg_wdata_i | input | BUS_W | Write data (byte in lanes 7:0 and 23:16) |
| reg_rdata_o | output | BUS_W | Registered read data, byte replicated |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event input is a single-cycle pulse and that an access lasts exactly one cycle with `reg_sel_i` high. They also assume the live levels change only between accesses. The stimulus drives every input just after a falling edge. It holds each pulse and each access for one cycle and leaves an idle cycle between them. The mode levels are set at least one cycle before the pulse or access that depends on them, so that the registered transmitter bit already holds its new value.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int NUM_FLAGS = 8;

  typedef enum logic [2:0] {
    FL_SB    = 3'd0,
    FL_HDR10 = 3'd1,
    FL_BTF   = 3'd2,
    FL_ENDAD = 3'd3,
    FL_AF    = 3'd4,
    FL_STOPF = 3'd5,
    FL_ARLO  = 3'd6,
    FL_BERR  = 3'd7
  } flag_e;

  localparam int OFS_CR  = 0;
  localparam int OFS_SR1 = 1;
  localparam int OFS_SR2 = 2;
  localparam int OFS_DR  = 6;

  localparam int CR_IE = 0;
  localparam int CR_PE = 5;

endpackage

// File: rtl/i2c_stat_bus.sv
module i2c_stat_bus
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              cr_wr_o,
  output logic              dr_wr_o,
  output logic              dr_rd_o,
  output logic              sr2_rd_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] wbyte_o
);
  localparam int HI = BUS_W / 2;

  logic lane_ok;
  logic wr_ok;
  logic unused_lanes;

  assign lane_ok      = (wdata_i[DATA_W-1:0] == wdata_i[HI +: DATA_W]);
  assign wr_ok        = sel_i && wr_i && lane_ok;
  assign rd_o         = sel_i && !wr_i;
  assign wbyte_o      = wdata_i[DATA_W-1:0];
  assign unused_lanes = ^{wdata_i[HI-1:DATA_W], wdata_i[BUS_W-1:HI+DATA_W]};

  assign cr_wr_o  = wr_ok && (int'(addr_i) == OFS_CR);
  assign dr_wr_o  = wr_ok && (int'(addr_i) == OFS_DR);
  assign dr_rd_o  = rd_o && (int'(addr_i) == OFS_DR);
  assign sr2_rd_o = rd_o && (int'(addr_i) == OFS_SR2);

endmodule

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic nxt_o
);
  always_comb begin
    if (hold_i)     nxt_o = 1'b0;
    else if (set_i) nxt_o = 1'b1;
    else if (clr_i) nxt_o = 1'b0;
    else            nxt_o = q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i && !hold_i |=> q_o);

  // R12
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !q_o);

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q_o) |-> $past(clr_i || hold_i || rst));

endmodule

// File: rtl/i2c_stat_rd.sv
module i2c_stat_rd #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [BUS_W-1:0]  word_o
);
  localparam int LANES = BUS_W / DATA_W;

  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst)       byte_q <= '0;
    else if (rd_i) byte_q <= byte_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start_i,
  input  logic              ev_hdr10_i,
  input  logic              ev_byte_i,
  input  logic              ev_addr_end_i,
  input  logic              ev_ack_fail_i,
  input  logic              ev_stop_i,
  input  logic              ev_arb_lost_i,
  input  logic              ev_bus_err_i,
  input  logic              bus_busy_i,
  input  logic              transmit_i,
  input  logic              master_i,
  input  logic              addressed_i,
  input  logic [DATA_W-1:0] data_byte_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int NF = NUM_FLAGS;
  localparam int HI = BUS_W / 2;

  logic              cr_wr, dr_wr, dr_rd, sr2_rd, rd_en;
  logic [DATA_W-1:0] wbyte;
  logic [DATA_W-1:0] cr_q, cr_nxt;
  logic              tra_q, msl_q, busy_q, adsl_q;
  logic [NF-1:0]     flag_set, flag_clr, flag_q, flag_nxt;
  logic              hold;
  logic              evf;
  logic              irq_q;
  logic [DATA_W-1:0] rbyte;

  i2c_stat_bus #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_bus (
    .sel_i   (reg_sel_i),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cr_wr_o (cr_wr),
    .dr_wr_o (dr_wr),
    .dr_rd_o (dr_rd),
    .sr2_rd_o(sr2_rd),
    .rd_o    (rd_en),
    .wbyte_o (wbyte)
  );

  assign cr_nxt = cr_wr ? wbyte : cr_q;
  assign hold   = !cr_nxt[CR_PE];

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q   <= '0;
      tra_q  <= 1'b0;
      msl_q  <= 1'b0;
      busy_q <= 1'b0;
      adsl_q <= 1'b0;
    end else begin
      cr_q   <= cr_nxt;
      tra_q  <= transmit_i;
      msl_q  <= master_i;
      busy_q <= bus_busy_i;
      adsl_q <= addressed_i;
    end
  end

  assign flag_set = {ev_bus_err_i, ev_arb_lost_i, ev_stop_i, ev_ack_fail_i,
                     ev_addr_end_i, ev_byte_i, ev_hdr10_i, ev_start_i};

  always_comb begin
    flag_clr           = '0;
    flag_clr[FL_SB]    = dr_wr;
    flag_clr[FL_HDR10] = dr_wr;
    flag_clr[FL_BTF]   = (dr_wr && tra_q) || (dr_rd && !tra_q);
    flag_clr[FL_ENDAD] = cr_wr && wbyte[CR_PE];
    flag_clr[FL_AF]    = sr2_rd;
    flag_clr[FL_STOPF] = sr2_rd;
    flag_clr[FL_ARLO]  = sr2_rd;
    flag_clr[FL_BERR]  = sr2_rd;
  end

  for (genvar g = 0; g < NF; g++) begin : g_flag
    i2c_stat_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .hold_i(hold),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .q_o   (flag_q[g]),
      .nxt_o (flag_nxt[g])
    );
  end

  assign evf = |flag_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|flag_nxt) && cr_nxt[CR_IE];
  end
  assign irq_o = irq_q;

  always_comb begin
    rbyte = '0;
    case (int'(reg_addr_i))
      OFS_CR:  rbyte = cr_q;
      OFS_SR1: rbyte = {evf, flag_q[FL_HDR10], tra_q, busy_q,
                        flag_q[FL_BTF], adsl_q, msl_q, flag_q[FL_SB]};
      OFS_SR2: rbyte = {2'b00, flag_q[FL_ENDAD], flag_q[FL_AF],
                        flag_q[FL_STOPF], flag_q[FL_ARLO], flag_q[FL_BERR], 1'b0};
      OFS_DR:  rbyte = data_byte_i;
      default: rbyte = '0;
    endcase
  end

  i2c_stat_rd #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_i  (rd_en),
    .byte_i(rbyte),
    .word_o(reg_rdata_o)
  );

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> cr_q[CR_IE]);

  // R2
  lane_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel_i && reg_wr_i && (reg_wdata_i[7:0] != reg_wdata_i[HI +: 8])
    |=> $stable(cr_q));

  // R4
  busy_track_chk: assert property (@(posedge clk) disable iff (rst)
    bus_busy_i |=> busy_q);

  // R9
  sr2_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_sel_i && !reg_wr_i && (int'(reg_addr_i) == OFS_SR2) && !ev_ack_fail_i
    |=> !flag_q[FL_AF]);

endmodule

// File: tb/i2c_stat_irq_tb.sv
module i2c_stat_irq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  ev = '0;
  logic        busy = 1'b0, tx = 1'b0, mst = 1'b0, adr = 1'b0;
  logic [7:0]  dbyte = 8'h5C;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_stat_irq u_dut (
    .clk(clk), .rst(rst),
    .ev_start_i(ev[0]), .ev_hdr10_i(ev[1]), .ev_byte_i(ev[2]),
    .ev_addr_end_i(ev[3]), .ev_ack_fail_i(ev[4]), .ev_stop_i(ev[5]),
    .ev_arb_lost_i(ev[6]), .ev_bus_err_i(ev[7]),
    .bus_busy_i(busy), .transmit_i(tx), .master_i(mst), .addressed_i(adr),
    .data_byte_i(dbyte), .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {ev[7:0], tx, act[1:0], irq, sr1, sr2}; act 0 none, 1 data write, 2 data read, 3 control write
  localparam logic [27:0] VEC [0:12] = '{
    {8'h01, 1'b1, 2'd0, 1'b1, 8'hB3, 8'h00},
    {8'h00, 1'b1, 2'd1, 1'b0, 8'h32, 8'h00},
    {8'h08, 1'b1, 2'd0, 1'b1, 8'hB2, 8'h20},
    {8'h00, 1'b1, 2'd3, 1'b0, 8'h32, 8'h00},
    {8'h04, 1'b1, 2'd0, 1'b1, 8'hBA, 8'h00},
    {8'h00, 1'b1, 2'd2, 1'b1, 8'hBA, 8'h00},
    {8'h00, 1'b1, 2'd1, 1'b0, 8'h32, 8'h00},
    {8'h04, 1'b0, 2'd1, 1'b1, 8'h9A, 8'h00},
    {8'h00, 1'b0, 2'd2, 1'b0, 8'h12, 8'h00},
    {8'h50, 1'b0, 2'd0, 1'b1, 8'h92, 8'h14},
    {8'h00, 1'b0, 2'd0, 1'b0, 8'h12, 8'h00},
    {8'hA2, 1'b1, 2'd0, 1'b1, 8'hF2, 8'h0A},
    {8'h00, 1'b1, 2'd1, 1'b0, 8'h32, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {b, b, b, b};
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    chk(rdata == 32'h0, "R1 rdata", rdata, 32'h0);
    bread(3'd1, r); chk(r == 32'h0, "R1 sr1", r, 32'h0);
    bread(3'd2, r); chk(r == 32'h0, "R1 sr2", r, 32'h0);
    bread(3'd0, r); chk(r == 32'h0, "R1 cr", r, 32'h0);
    // R12 events ignored while disabled
    pulse(8'hFF);
    bread(3'd1, r); chk(r == 32'h0, "R12 disabled sr1", r, 32'h0);
    bread(3'd2, r); chk(r == 32'h0, "R12 disabled sr2", r, 32'h0);
    // R3 data offset replicated
    bread(3'd6, r); chk(r == 32'h5C5C5C5C, "R3 data read", r, 32'h5C5C5C5C);

    busy = 1'b1; mst = 1'b1;
    bwrite(3'd0, 32'h00210021);
    bread(3'd0, r); chk(r == rep(8'h21), "R3 cr read", r, rep(8'h21));

    // vector table: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 13; i++) begin
      logic [27:0] v;
      v = VEC[i];
      tx = v[19];
      pulse(v[27:20]);
      case (v[18:17])
        2'd1: bwrite(3'd6, 32'h00AA00AA);
        2'd2: bread(3'd6, r);
        2'd3: bwrite(3'd0, 32'h00210021);
        default: ;
      endcase
      @(negedge clk);
      chk(irq == v[16], $sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, v[16]});
      bread(3'd1, r); chk(r == rep(v[15:8]), $sformatf("R4 R6 R7 vec%0d sr1", i), r, rep(v[15:8]));
      bread(3'd2, r); chk(r == rep(v[7:0]), $sformatf("R5 R8 R9 vec%0d sr2", i), r, rep(v[7:0]));
    end

    // R2 mismatched lanes ignored (tx=1)
    pulse(8'h01);
    bwrite(3'd6, 32'h00000011);
    bread(3'd1, r); chk(r == rep(8'hB3), "R2 data write ignored", r, rep(8'hB3));
    bwrite(3'd0, 32'h00010000);
    bread(3'd0, r); chk(r == rep(8'h21), "R2 control write ignored", r, rep(8'h21));
    bwrite(3'd6, 32'h00110011);
    bread(3'd1, r); chk(r == rep(8'h32), "R6 valid write clears", r, rep(8'h32));

    // R10 interrupt enable off
    bwrite(3'd0, 32'h00200020);
    pulse(8'h01);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq gated", {31'b0, irq}, 32'h0);
    bread(3'd1, r); chk(r == rep(8'hB3), "R10 summary without irq", r, rep(8'hB3));

    // R12 disable clears flags
    bwrite(3'd0, 32'h00000000);
    bread(3'd1, r); chk(r == rep(8'h32), "R12 disable clears", r, rep(8'h32));
    bwrite(3'd0, 32'h00210021);

    // R11 set wins over same-cycle clear
    @(negedge clk); ev = 8'h01; sel = 1'b1; wr = 1'b1; addr = 3'd6; wdata = 32'h00330033;
    @(negedge clk); ev = '0; sel = 1'b0; wr = 1'b0;
    chk(irq == 1'b1, "R11 irq", {31'b0, irq}, 32'h1);
    bread(3'd1, r); chk(r == rep(8'hB3), "R11 flag kept", r, rep(8'hB3));
    bwrite(3'd6, 32'h00330033);

    // R4 busy follows input, not cleared by reads
    busy = 1'b0;
    bread(3'd1, r); chk(r == rep(8'h22), "R4 busy low", r, rep(8'h22));
    busy = 1'b1;
    bread(3'd1, r); bread(3'd1, r2);
    chk(r == rep(8'h32) && r2 == rep(8'h32), "R4 busy kept", r2, rep(8'h32));

    // R9 status-1 read clears nothing
    pulse(8'h10);
    bread(3'd1, r); bread(3'd1, r2);
    chk(r2 == rep(8'hB2), "R9 sr1 read no clear", r2, rep(8'hB2));
    bread(3'd2, r); chk(r == rep(8'h10), "R9 sr2 shows af", r, rep(8'h10));
    bread(3'd2, r); chk(r == 32'h0, "R9 sr2 cleared", r, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule